// File: doc/BRIEF.md
# Nibble-Safe SEC-DED Memory ECC Codec

This block protects a 32-bit memory data word with 8 check bits. On the write side it turns the outgoing data word into check bits with no clock in the path, so a full-word store gains no latency. On the read side it takes the returned data word and its stored check bits and computes a syndrome. It repairs any single flipped bit and reports the read as corrected. Any double-bit error, and any damage of two to four bits confined to one aligned 4-bit nibble, is reported as uncorrectable and never miscorrected.

The decoder is combinational up to the read capture register. The corrected word, the flags and the raw syndrome are therefore registered on the same edge that would capture the raw data without ECC. A check-enable input turns the read side into a plain pass-through, with the flags held low. The parity-check matrix is fixed. The column for data bit 4k+i (nibble k, bit i) sets rows k, (k+1) mod 8 and (k+3+i) mod 8. Check bit j sets only row 2j for j<4, and only row 2(j-4)+1 for j>=4.

Top module: `ecc_nib_codec`

## Requirements
- R1: `wr_check` follows `wr_data` combinationally in the same cycle. Check bit j is the XOR of every data bit whose column (as defined above) sets the row that check bit j covers. A read of that unaltered pair gives a zero syndrome, the data unchanged and both flags low.
- R2: A read is captured on the rising clock edge at which `rd_valid` is high, and `out_valid` is high for the cycle that follows. On an edge with `rd_valid` low, `out_valid` falls and `out_data`, `out_corr`, `out_uncorr` and `out_syndrome` keep their values.
- R3: When exactly one data bit differs from the encoded word, `out_data` returns the original word and `out_corr` is 1.
- R4: When exactly one check bit differs, `out_data` equals the read data and `out_corr` is 1.
- R5: Any two flipped bits among the 40 stored bits give `out_uncorr` = 1 and `out_corr` = 0, and `out_data` equals the read data without any bit flipped.
- R6: Any pattern of two to four flipped bits inside one aligned nibble gives `out_uncorr` = 1 and no bit flipped. The aligned nibbles are data bits 4k..4k+3, check bits 0..3 and check bits 4..7.
- R7: With `chk_en` low at capture, `out_data` is the read data unchanged and both flags are 0.
- R8: `out_syndrome` is the XOR, over all 40 read bits that are 1, of their matrix columns, whatever the state of `chk_en`.
- R9: While `rst_n` is low, every output register is 0.
- R10: `out_corr` and `out_uncorr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 32 | Data word being written |
| wr_check | output | 8 | Check bits for `wr_data`, combinational |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | 32 | Data word read from memory |
| rd_check | input | 8 | Check bits read from memory |
| chk_en | input | 1 | Enables correction and flags |
| out_valid | output | 1 | Registered read result is valid |
| out_data | output | 32 | Corrected (or passed) read data |
| out_corr | output | 1 | A single-bit error was corrected |
| out_uncorr | output | 1 | An uncorrectable error was detected |
| out_syndrome | output | 8 | Raw syndrome of the captured read |

## Verification
`wr_check` is due in the cycle its data is applied. The bench drives inputs on the falling edge and samples the check bits 1 ns later, well before the next rising edge. Every read result is due one rising edge after its inputs are applied. The bench compares all read outputs 1 ns after that edge against a behavioural model. The model builds the matrix columns with its own arithmetic and searches for a match. Idle cycles are compared the same way, so the hold behaviour is checked on the cycle it applies.

// File: rtl/ecc_nib_pkg.sv
`timescale 1ns/1ps
package ecc_nib_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CHK_W     = 8;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned CODE_W    = DATA_W + CHK_W;
  localparam int unsigned HALF_CHK  = CHK_W / 2;
  localparam int unsigned WIDE_OFS  = 3;

  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [DATA_W-1:0] word_t;

  // Row of the syndrome covered by check bit j: even rows first, then odd.
  // This keeps every 3-of-4 subset of a check nibble free of adjacent rows.
  function automatic int unsigned chk_row(int unsigned j);
    return (j < HALF_CHK) ? (2 * j) : (2 * (j - HALF_CHK) + 1);
  endfunction

  // Column of the parity-check matrix for code bit pos.
  // Data columns have weight 3 with exactly one cyclically adjacent row pair
  // (k, k+1) and a third row at offset 3..6; check columns have weight 1.
  function automatic syn_t h_col(int unsigned pos);
    syn_t c;
    int unsigned k;
    int unsigned i;
    c = '0;
    if (pos < DATA_W) begin
      k = pos / NIB_W;
      i = pos % NIB_W;
      c = c | (syn_t'(1) << (k % CHK_W));
      c = c | (syn_t'(1) << ((k + 1) % CHK_W));
      c = c | (syn_t'(1) << ((k + WIDE_OFS + i) % CHK_W));
    end else begin
      c = syn_t'(1) << chk_row(pos - DATA_W);
    end
    return c;
  endfunction

  // Contribution of the data bits to the syndrome.
  function automatic syn_t data_parity(word_t d);
    syn_t acc;
    acc = '0;
    for (int p = 0; p < DATA_W; p++) begin
      if (d[p]) acc = acc ^ h_col(p);
    end
    return acc;
  endfunction

  // Contribution of the stored check bits to the syndrome.
  function automatic syn_t check_parity(logic [CHK_W-1:0] c);
    syn_t acc;
    acc = '0;
    for (int j = 0; j < CHK_W; j++) begin
      if (c[j]) acc = acc ^ h_col(DATA_W + j);
    end
    return acc;
  endfunction

  // Reorder row parities into check-bit order.
  function automatic logic [CHK_W-1:0] rows_to_check(syn_t rows);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int j = 0; j < CHK_W; j++) begin
      c[j] = |(rows & (syn_t'(1) << chk_row(j)));
    end
    return c;
  endfunction
endpackage

// File: rtl/ecc_nib_encoder.sv
`timescale 1ns/1ps
module ecc_nib_encoder
  import ecc_nib_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  syn_t row_par;

  assign row_par = data_parity(data);
  assign check   = rows_to_check(row_par);
endmodule

// File: rtl/ecc_nib_syndrome.sv
`timescale 1ns/1ps
module ecc_nib_syndrome
  import ecc_nib_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  check,
  output logic [CHK_W-1:0]  syn
);
  syn_t data_rows;
  syn_t check_rows;

  assign data_rows  = data_parity(data);
  assign check_rows = check_parity(check);
  assign syn        = data_rows ^ check_rows;
endmodule

// File: rtl/ecc_nib_locator.sv
`timescale 1ns/1ps
module ecc_nib_locator
  import ecc_nib_pkg::*;
(
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] data_flip,
  output logic              data_hit,
  output logic              check_hit,
  output logic              syn_zero,
  output logic              syn_bad
);
  logic [CODE_W-1:0] match;

  for (genvar p = 0; p < CODE_W; p++) begin : g_col
    localparam syn_t COL = h_col(p);
    assign match[p] = (syn == COL);
  end

  assign data_flip = match[DATA_W-1:0];
  assign data_hit  = |match[DATA_W-1:0];
  assign check_hit = |match[CODE_W-1:DATA_W];
  assign syn_zero  = (syn == '0);
  assign syn_bad   = !syn_zero && !data_hit && !check_hit;
endmodule

// File: rtl/ecc_nib_codec.sv
`timescale 1ns/1ps
module ecc_nib_codec
  import ecc_nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       wr_data,
  output logic [7:0]        wr_check,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  input  logic [7:0]        rd_check,
  input  logic              chk_en,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_corr,
  output logic              out_uncorr,
  output logic [7:0]        out_syndrome
);
  // Named internal events, shared with the assertions below.
  logic [CHK_W-1:0]  rd_syn;
  logic [DATA_W-1:0] data_flip;
  logic              data_hit;
  logic              check_hit;
  logic              syn_zero;
  logic              syn_bad;
  logic              fix_hit;
  logic [DATA_W-1:0] fixed_data;

  ecc_nib_encoder u_enc (
    .data  (wr_data),
    .check (wr_check)
  );

  ecc_nib_syndrome u_syn (
    .data  (rd_data),
    .check (rd_check),
    .syn   (rd_syn)
  );

  ecc_nib_locator u_loc (
    .syn       (rd_syn),
    .data_flip (data_flip),
    .data_hit  (data_hit),
    .check_hit (check_hit),
    .syn_zero  (syn_zero),
    .syn_bad   (syn_bad)
  );

  assign fix_hit    = data_hit | check_hit;
  assign fixed_data = rd_data ^ data_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data     <= '0;
      out_corr     <= 1'b0;
      out_uncorr   <= 1'b0;
      out_syndrome <= '0;
    end else if (rd_valid) begin
      out_data     <= chk_en ? fixed_data : rd_data;
      out_corr     <= chk_en & fix_hit;
      out_uncorr   <= chk_en & syn_bad;
      out_syndrome <= rd_syn;
    end
  end

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corr && out_uncorr));

  // R3
  single_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(data_flip) <= 1) && !(data_hit && check_hit));

  // R2
  capture_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid && $stable(out_data) && $stable(out_syndrome)
                  && $stable(out_corr) && $stable(out_uncorr));

  // R1
  clean_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && chk_en && syn_zero) |=>
      (out_data == $past(rd_data)) && !out_corr && !out_uncorr);

  // R5
  fatal_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && chk_en && syn_bad) |=>
      out_uncorr && (out_data == $past(rd_data)));

  // R7
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !chk_en) |=>
      !out_corr && !out_uncorr && (out_data == $past(rd_data)));

  // R8
  syndrome_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (out_syndrome == $past(rd_syn)));
endmodule

// File: tb/test_ecc_nib_codec.sv
`timescale 1ns/1ps
module test_ecc_nib_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic        chk_en = 1'b1;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_corr;
  logic        out_uncorr;
  logic [7:0]  out_syndrome;

  always #2 clk = ~clk;

  ecc_nib_codec i_ecc_nib_codec (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_data      (wr_data),
    .wr_check     (wr_check),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_check     (rd_check),
    .chk_en       (chk_en),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_corr     (out_corr),
    .out_uncorr   (out_uncorr),
    .out_syndrome (out_syndrome)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] seed = 32'h1badf00d;

  // Reference model state
  logic        m_valid  = 0;
  logic [31:0] m_data   = '0;
  logic        m_corr   = 0;
  logic        m_uncorr = 0;
  logic [7:0]  m_syn    = '0;

  function automatic logic [7:0] ref_col(int b);
    int k, i, j;
    if (b < 32) begin
      k = b >> 2;
      i = b & 3;
      return 8'((1 << k) | (1 << ((k + 1) & 7)) | (1 << ((k + 3 + i) & 7)));
    end
    j = b - 32;
    if (j < 4) return 8'(1 << (2 * j));
    return 8'(1 << (2 * j - 7));
  endfunction

  function automatic logic [7:0] ref_check(logic [31:0] d);
    logic [7:0] c;
    logic [7:0] col;
    int row;
    c = '0;
    for (int j = 0; j < 8; j++) begin
      row = (j < 4) ? 2 * j : 2 * j - 7;
      for (int b = 0; b < 32; b++) begin
        col = ref_col(b);
        if (d[b] && col[row]) c[j] = ~c[j];
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] ref_syn(logic [39:0] w);
    logic [7:0] s;
    s = '0;
    for (int b = 0; b < 40; b++) if (w[b]) s = s ^ ref_col(b);
    return s;
  endfunction

  function automatic logic [31:0] rnd(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [7:0] c,
                      input bit v, input bit en, input string tag);
    logic [7:0] s;
    int hit;
    @(negedge clk);
    wr_data  = d;
    rd_data  = d;
    rd_check = c;
    rd_valid = v;
    chk_en   = en;
    #1;
    chk("R1", "wr_check", wr_check, ref_check(d));
    m_valid = v;
    if (v) begin
      s = ref_syn({c, d});
      m_syn = s;
      m_data = d;
      m_corr = 0;
      m_uncorr = 0;
      if (en && s != 0) begin
        hit = -1;
        for (int b = 0; b < 40; b++) if (ref_col(b) == s) hit = b;
        if (hit < 0) m_uncorr = 1;
        else begin
          m_corr = 1;
          if (hit < 32) m_data = d ^ (32'(1) << hit);
        end
      end
    end
    @(posedge clk);
    #1;
    chk("R2", "out_valid", out_valid, m_valid);
    chk(tag, "out_data", out_data, m_data);
    chk(tag, "out_corr", out_corr, m_corr);
    chk(tag, "out_uncorr", out_uncorr, m_uncorr);
    chk("R8", "out_syndrome", out_syndrome, m_syn);
    chk("R10", "flags exclusive", out_corr & out_uncorr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [39:0] w;
    logic [39:0] m;
    int a, b;
    logic [31:0] clean_pats [6];
    clean_pats[0] = 32'h0000_0000;
    clean_pats[1] = 32'hffff_ffff;
    clean_pats[2] = 32'ha5a5_a5a5;
    clean_pats[3] = 32'h1234_5678;
    clean_pats[4] = 32'h8000_0001;
    clean_pats[5] = 32'hdead_beef;

    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "out_data", out_data, 0);
    chk("R9", "out_corr", out_corr, 0);
    chk("R9", "out_uncorr", out_uncorr, 0);
    chk("R9", "out_syndrome", out_syndrome, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: clean round trips
    foreach (clean_pats[p]) begin
      send(clean_pats[p], ref_check(clean_pats[p]), 1, 1, "R1");
      chk("R1", "clean syndrome", out_syndrome, 0);
    end

    // R3: every single data bit
    for (int bit_i = 0; bit_i < 32; bit_i++) begin
      seed = rnd(seed);
      d = seed;
      send(d ^ (32'(1) << bit_i), ref_check(d), 1, 1, "R3");
      chk("R3", "restored data", out_data, d);
      chk("R3", "corr flag", out_corr, 1);
    end

    // R4: every single check bit
    for (int j = 0; j < 8; j++) begin
      seed = rnd(seed);
      d = seed;
      send(d, ref_check(d) ^ (8'(1) << j), 1, 1, "R4");
      chk("R4", "data kept", out_data, d);
      chk("R4", "corr flag", out_corr, 1);
    end

    // R2: idle cycles hold results
    send(32'h0bad_cafe, 8'h00, 0, 1, "R2");
    send(32'h0000_1111, 8'hff, 0, 0, "R2");

    // R5: double errors anywhere in the 40 bits
    for (int n = 0; n < 60; n++) begin
      seed = rnd(seed);
      d = seed;
      seed = rnd(seed);
      a = int'(seed % 40);
      seed = rnd(seed);
      b = (a + 1 + int'(seed % 39)) % 40;
      m = (40'(1) << a) | (40'(1) << b);
      w = {ref_check(d), d} ^ m;
      send(w[31:0], w[39:32], 1, 1, "R5");
      chk("R5", "uncorr flag", out_uncorr, 1);
      chk("R5", "raw data", out_data, w[31:0]);
    end

    // R6: every multi-bit pattern inside each aligned nibble
    for (int nib = 0; nib < 10; nib++) begin
      for (int pat = 1; pat < 16; pat++) begin
        if ($countones(4'(pat)) >= 2) begin
          seed = rnd(seed);
          d = seed;
          m = 40'(pat) << (4 * nib);
          w = {ref_check(d), d} ^ m;
          send(w[31:0], w[39:32], 1, 1, "R6");
          chk("R6", "uncorr flag", out_uncorr, 1);
          chk("R6", "raw data", out_data, w[31:0]);
        end
      end
    end

    // R7: check disabled passes errors through quietly
    for (int n = 0; n < 4; n++) begin
      seed = rnd(seed);
      d = seed;
      w = {ref_check(d), d} ^ (40'(3) << (n * 9));
      send(w[31:0], w[39:32], 1, 0, "R7");
      chk("R7", "passthrough", out_data, w[31:0]);
      chk("R7", "flags low", {out_corr, out_uncorr}, 0);
    end
    send(d ^ 32'h10, ref_check(d), 1, 0, "R7");
    chk("R7", "single not fixed", out_data, d ^ 32'h10);

    // R2: back-to-back after idle
    send(32'h5555_aaaa, ref_check(32'h5555_aaaa), 1, 1, "R2");
    send(32'h5555_aaab, ref_check(32'h5555_aaaa), 1, 1, "R2");
    send(32'h0, 8'h0, 0, 1, "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule